// File: doc/BRIEF.md
# Pipelined Binary Heap Priority Queue

This block is a min-priority queue for timestamped simulation events. The entries are kept in a binary heap. Each heap level is handled by its own pipeline stage, and each stage owns one token register. An insert enters at the root and moves down one level per cycle. At each level it keeps the smaller of the travelling entry and the resident entry, and it carries the larger one further down. The path of an insert is steered by two vacancy counts stored in every node, one for the subtree under each child, so no search is ever needed.

A dequeue returns the root entry. It then leaves a hole that travels down the tree: at each level the smaller valid child is promoted into the hole. Each stage touches at most its own level and the level below it. Because of this, a new operation can be accepted every second cycle, whatever the depth. Operations already in flight continue underneath a newly accepted one.

Each entry is 64 bits wide. The upper 32 bits hold the ordering key (the event timestamp). The lower 32 bits are carried along unchanged (target process id and payload). With the default of 10 levels the queue holds 1023 entries.

Top module: `minheap_pipe`

## Requirements
- R1: After reset `heapEmpty` is 1, `heapFull` is 0, `opReady` is 1 and `deqValid` is 0.
- R2: An accepted dequeue returns an entry whose key (bits 63:32) is the smallest key held. Bits 31:0 come back exactly as they were inserted.
- R3: After an accepted request, `opReady` is 0 for exactly one cycle. Any request made while `opReady` is 0 is ignored.
- R4: `heapFull` is 1 when 2^LEVELS-1 entries are held. An insert made while full is ignored and does not change what later dequeues return.
- R5: A dequeue made while empty is ignored: `deqValid` stays 0 and `heapEmpty` stays 1.
- R6: When both `insReq` and `deqReq` are high in an accepted cycle, the dequeue is performed and the insert is dropped.
- R7: Entries with equal keys are all kept, and all of them come out. Among themselves they may leave in any order.
- R8: In every cycle in which `opReady` is 1, `heapEmpty` and `heapFull` match the number of entries held.
- R9: Operations issued every second cycle, with inserts and dequeues mixed, give the same results as the same operations issued one at a time.
- R10: `deqValid` is high for exactly the one cycle after an accepted dequeue, and `deqEntry` holds the returned entry in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| insReq | input | 1 | Insert request |
| insEntry | input | 64 | Entry to insert; key in bits 63:32 |
| deqReq | input | 1 | Dequeue request |
| deqValid | output | 1 | Returned entry is valid this cycle |
| deqEntry | output | 64 | Returned entry |
| opReady | output | 1 | A request made this cycle can be accepted |
| heapEmpty | output | 1 | No entry held |
| heapFull | output | 1 | Every slot held |

## Verification
Several insert orders are tried, and each one exercises a different part of the design:
- Descending keys force every insert to displace the resident entry, so the comparison and the carry-down path are tested.
- A pseudo-random permutation filled to capacity spreads inserts over both subtrees at every level, which tests the vacancy steering and the full flag.
- An interleaved stream of inserts and dequeues at the maximum rate tests that operations in flight at different depths do not disturb each other.
- Duplicate keys with distinct payloads show that no entry is lost or duplicated when keys tie.

Rejection cases are checked at the ports: dequeue while empty, insert while full, requests made during the busy cycle, and simultaneous requests.

// File: rtl/mhp_pkg.sv
package mhp_pkg;
  localparam int LEVELS  = 10;
  localparam int ENTRY_W = 64;
  localparam int KEY_W   = 32;
  localparam int IDX_W   = LEVELS;
  localparam int CAP_W   = LEVELS;
  localparam int MEM_SZ  = 2 ** LEVELS;

  typedef enum logic [1:0] {OP_NONE, OP_INS, OP_DEQ} opKind_e;

  typedef struct packed {
    logic               vld;
    logic [CAP_W-1:0]   capL;
    logic [CAP_W-1:0]   capR;
    logic [ENTRY_W-1:0] ent;
  } node_t;

  typedef struct packed {
    opKind_e            op;
    logic [IDX_W-1:0]   idx;
    logic [ENTRY_W-1:0] ent;
  } token_t;

  typedef struct packed {
    logic issueIns;
    logic issueDeq;
  } ctrlStrobe_t;

  function automatic logic [KEY_W-1:0] keyOf(input logic [ENTRY_W-1:0] e);
    return e[ENTRY_W-1 -: KEY_W];
  endfunction

  // Empty node at heap index i: each child subtree fully vacant.
  function automatic node_t resetNode(input int i);
    node_t n;
    int lv;
    n  = '0;
    lv = 0;
    for (int j = 1; j < LEVELS; j++) if (i >= (1 << j)) lv = j;
    n.capL = CAP_W'((1 << (LEVELS - 1 - lv)) - 1);
    n.capR = n.capL;
    return n;
  endfunction
endpackage

// File: rtl/mhp_ctrl.sv
module mhp_ctrl
  import mhp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        insReq,
  input  logic        deqReq,
  input  logic        rootVld,
  input  logic        rootFree,
  output ctrlStrobe_t strobe,
  output logic        opReady,
  output logic        heapEmpty,
  output logic        heapFull
);
  logic coolDown;

  always_comb begin
    heapEmpty       = !rootVld;
    heapFull        = rootVld && !rootFree;
    opReady         = !coolDown;
    strobe.issueDeq = deqReq && !coolDown && !heapEmpty;
    strobe.issueIns = insReq && !deqReq && !coolDown && !heapFull;
  end

  always_ff @(posedge clk) begin
    if (!rstN) coolDown <= 1'b0;
    else       coolDown <= strobe.issueDeq || strobe.issueIns;
  end
endmodule

// File: rtl/mhp_datapath.sv
module mhp_datapath
  import mhp_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobe,
  input  logic [ENTRY_W-1:0] insEntry,
  output logic               rootVld,
  output logic               rootFree,
  output logic               deqValid,
  output logic [ENTRY_W-1:0] deqEntry
);
  localparam logic [CAP_W-1:0] CAP_ONE = CAP_W'(1);
  localparam logic [IDX_W-1:0] ROOT_IX = IDX_W'(1);

  node_t            nodeMem [MEM_SZ];
  token_t           tok     [LEVELS];
  token_t           nxtTok  [LEVELS-1];
  logic             wrEn    [LEVELS];
  logic [IDX_W-1:0] wrIdx   [LEVELS];
  node_t            wrNode  [LEVELS];

  assign rootVld  = nodeMem[1].vld;
  assign rootFree = (nodeMem[1].capL != '0) || (nodeMem[1].capR != '0);

  for (genvar k = 0; k < LEVELS; k++) begin : g_stage
    node_t cur;
    assign cur = nodeMem[tok[k].idx];

    if (k == LEVELS - 1) begin : g_leaf
      always_comb begin
        wrIdx[k]  = tok[k].idx;
        wrNode[k] = cur;
        wrEn[k]   = 1'b0;
        if (tok[k].op == OP_INS) begin
          wrNode[k].vld = 1'b1;
          wrNode[k].ent = tok[k].ent;
          wrEn[k]       = 1'b1;
        end else if (tok[k].op == OP_DEQ) begin
          wrNode[k].vld = 1'b0;
          wrEn[k]       = 1'b1;
        end
      end
    end else begin : g_inner
      logic [IDX_W-1:0] lIdx, rIdx;
      node_t            lNode, rNode;
      logic             keepNew, goRight, pickR;
      assign lIdx  = {tok[k].idx[IDX_W-2:0], 1'b0};
      assign rIdx  = {tok[k].idx[IDX_W-2:0], 1'b1};
      assign lNode = nodeMem[lIdx];
      assign rNode = nodeMem[rIdx];
      assign keepNew = keyOf(tok[k].ent) < keyOf(cur.ent);
      assign goRight = (cur.capL == '0);
      assign pickR   = !lNode.vld || (rNode.vld && (keyOf(rNode.ent) < keyOf(lNode.ent)));

      always_comb begin
        wrIdx[k]  = tok[k].idx;
        wrNode[k] = cur;
        wrEn[k]   = 1'b0;
        nxtTok[k] = '0;
        if (tok[k].op == OP_INS) begin
          wrEn[k] = 1'b1;
          if (!cur.vld) begin
            wrNode[k].vld = 1'b1;
            wrNode[k].ent = tok[k].ent;
          end else begin
            wrNode[k].ent = keepNew ? tok[k].ent : cur.ent;
            if (goRight) wrNode[k].capR = cur.capR - CAP_ONE;
            else         wrNode[k].capL = cur.capL - CAP_ONE;
            nxtTok[k].op  = OP_INS;
            nxtTok[k].idx = goRight ? rIdx : lIdx;
            nxtTok[k].ent = keepNew ? cur.ent : tok[k].ent;
          end
        end else if (tok[k].op == OP_DEQ) begin
          wrEn[k] = 1'b1;
          if (!lNode.vld && !rNode.vld) begin
            wrNode[k].vld = 1'b0;
          end else begin
            wrNode[k].ent = pickR ? rNode.ent : lNode.ent;
            if (pickR) wrNode[k].capR = cur.capR + CAP_ONE;
            else       wrNode[k].capL = cur.capL + CAP_ONE;
            nxtTok[k].op  = OP_DEQ;
            nxtTok[k].idx = pickR ? rIdx : lIdx;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < MEM_SZ; i++) nodeMem[i] <= resetNode(i);
      for (int k = 0; k < LEVELS; k++) tok[k] <= '0;
      deqValid <= 1'b0;
      deqEntry <= '0;
    end else begin
      for (int k = 0; k < LEVELS; k++)
        if (wrEn[k]) nodeMem[wrIdx[k]] <= wrNode[k];
      for (int k = 1; k < LEVELS; k++) tok[k] <= nxtTok[k-1];
      if (strobe.issueDeq)      tok[0] <= '{op: OP_DEQ, idx: ROOT_IX, ent: '0};
      else if (strobe.issueIns) tok[0] <= '{op: OP_INS, idx: ROOT_IX, ent: insEntry};
      else                      tok[0] <= '0;
      deqValid <= strobe.issueDeq;
      if (strobe.issueDeq) deqEntry <= nodeMem[1].ent;
    end
  end
endmodule

// File: rtl/minheap_pipe.sv
module minheap_pipe
  import mhp_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               insReq,
  input  logic [ENTRY_W-1:0] insEntry,
  input  logic               deqReq,
  output logic               deqValid,
  output logic [ENTRY_W-1:0] deqEntry,
  output logic               opReady,
  output logic               heapEmpty,
  output logic               heapFull
);
  ctrlStrobe_t strobe;
  logic        rootVld, rootFree;

  mhp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .insReq(insReq), .deqReq(deqReq),
    .rootVld(rootVld), .rootFree(rootFree), .strobe(strobe),
    .opReady(opReady), .heapEmpty(heapEmpty), .heapFull(heapFull)
  );

  mhp_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .insEntry(insEntry),
    .rootVld(rootVld), .rootFree(rootFree),
    .deqValid(deqValid), .deqEntry(deqEntry)
  );
endmodule

// File: rtl/mhp_checker.sv
module mhp_checker (
  input logic clk,
  input logic rstN,
  input logic insReq,
  input logic deqReq,
  input logic deqValid,
  input logic opReady,
  input logic heapEmpty,
  input logic heapFull
);
  AST_READY_GAP: assert property (@(posedge clk) disable iff (!rstN)
    (opReady && ((deqReq && !heapEmpty) || (insReq && !deqReq && !heapFull))) |=> !opReady); // R3
  AST_READY_BACK: assert property (@(posedge clk) disable iff (!rstN)
    !opReady |=> opReady); // R3
  AST_DEQ_SRC: assert property (@(posedge clk) disable iff (!rstN)
    deqValid |-> $past(opReady && deqReq && !heapEmpty)); // R10
  AST_DEQ_PRIO: assert property (@(posedge clk) disable iff (!rstN)
    (opReady && deqReq && !heapEmpty) |=> deqValid); // R6
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (opReady && heapFull && insReq && !deqReq) |=> (opReady && heapFull)); // R4
  AST_EMPTY_NODEQ: assert property (@(posedge clk) disable iff (!rstN)
    (opReady && heapEmpty && deqReq) |=> (!deqValid && heapEmpty)); // R5
endmodule

bind minheap_pipe mhp_checker u_chk (
  .clk(clk), .rstN(rstN), .insReq(insReq), .deqReq(deqReq),
  .deqValid(deqValid), .opReady(opReady), .heapEmpty(heapEmpty), .heapFull(heapFull)
);

// File: tb/sim_minheap_pipe.sv
module sim_minheap_pipe;
  localparam int CAP = 1023;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        insReq = 1'b0;
  logic [63:0] insEntry = '0;
  logic        deqReq = 1'b0;
  logic        deqValid, opReady, heapEmpty, heapFull;
  logic [63:0] deqEntry;

  int checks = 0;
  int errors = 0;
  logic [63:0] mdl [CAP];
  int mcnt = 0;

  always #4 clk = ~clk;

  minheap_pipe u0 (
    .clk(clk), .rstN(rstN), .insReq(insReq), .insEntry(insEntry),
    .deqReq(deqReq), .deqValid(deqValid), .deqEntry(deqEntry),
    .opReady(opReady), .heapEmpty(heapEmpty), .heapFull(heapFull)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one insert slot: request at a negedge, dropped at the next
  task automatic doIns(input logic [63:0] e);
    @(negedge clk);
    insReq = 1'b1; insEntry = e;
    @(negedge clk);
    insReq = 1'b0;
    if (mcnt < CAP) begin mdl[mcnt] = e; mcnt++; end
  endtask

  task automatic doDeq(input string tag);
    bit found;
    int hit;
    logic [31:0] minKey;
    @(negedge clk);
    deqReq = 1'b1;
    @(negedge clk);
    deqReq = 1'b0;
    if (mcnt == 0) begin
      chk(deqValid == 1'b0, {tag, " R5 deqValid on empty"}, 64'(deqValid), 64'd0);
    end else begin
      chk(deqValid == 1'b1, {tag, " R10 deqValid"}, 64'(deqValid), 64'd1);
      minKey = mdl[0][63:32];
      for (int j = 1; j < mcnt; j++) if (mdl[j][63:32] < minKey) minKey = mdl[j][63:32];
      found = 0; hit = 0;
      for (int j = 0; j < mcnt; j++) if (!found && mdl[j] == deqEntry) begin found = 1; hit = j; end
      chk(deqEntry[63:32] == minKey && found, {tag, " R2 min entry"}, deqEntry, {minKey, 32'h0});
      if (found) begin mdl[hit] = mdl[mcnt-1]; mcnt--; end
    end
  endtask

  task automatic drainAll(input string tag);
    while (mcnt > 0) doDeq(tag);
    @(negedge clk);
    chk(heapEmpty == 1'b1, {tag, " R8 empty after drain"}, 64'(heapEmpty), 64'd1);
  endtask

  task automatic testReset;
    chk(heapEmpty == 1'b1, "R1 empty", 64'(heapEmpty), 64'd1);
    chk(heapFull == 1'b0, "R1 full", 64'(heapFull), 64'd0);
    chk(opReady == 1'b1, "R1 ready", 64'(opReady), 64'd1);
    chk(deqValid == 1'b0, "R1 deqValid", 64'(deqValid), 64'd0);
  endtask

  task automatic testDescending;
    for (int i = 0; i < 12; i++) doIns({32'(100 - i * 7), 32'(i + 32'hA0)});
    @(negedge clk);
    chk(heapEmpty == 1'b0, "R8 not empty", 64'(heapEmpty), 64'd0);
    drainAll("R2 descending");
  endtask

  task automatic testInterleave;
    for (int i = 0; i < 40; i++) begin
      doIns({32'((i * 53 + 17) % 97), 32'(i)});
      if (i % 3 == 2) doDeq("R9 interleave");
    end
    drainAll("R9 interleave");
  endtask

  task automatic testTies;
    for (int i = 0; i < 5; i++) doIns({32'd5, 32'(i + 1)});
    doIns({32'd9, 32'hBEEF});
    doIns({32'd2, 32'hCAFE});
    drainAll("R7 ties");
  endtask

  task automatic testEmptyDeq;
    doDeq("R5 empty");
    @(negedge clk);
    chk(deqValid == 1'b0, "R5 still no deqValid", 64'(deqValid), 64'd0);
    chk(heapEmpty == 1'b1, "R5 still empty", 64'(heapEmpty), 64'd1);
  endtask

  task automatic testReadyGap;
    @(negedge clk);
    insReq = 1'b1; insEntry = {32'd40, 32'h1};
    @(negedge clk);
    chk(opReady == 1'b0, "R3 ready low after accept", 64'(opReady), 64'd0);
    insEntry = {32'd10, 32'h2};
    @(negedge clk);
    insReq = 1'b0;
    mdl[mcnt] = {32'd40, 32'h1}; mcnt++;
    chk(opReady == 1'b1, "R3 ready back", 64'(opReady), 64'd1);
    doDeq("R3 first");
    @(negedge clk);
    chk(heapEmpty == 1'b1, "R3 second insert dropped", 64'(heapEmpty), 64'd1);
  endtask

  task automatic testPriority;
    doIns({32'd77, 32'h55});
    @(negedge clk);
    deqReq = 1'b1; insReq = 1'b1; insEntry = {32'd3, 32'h66};
    @(negedge clk);
    deqReq = 1'b0; insReq = 1'b0;
    chk(deqValid == 1'b1 && deqEntry == {32'd77, 32'h55}, "R6 dequeue wins", deqEntry, {32'd77, 32'h55});
    mcnt = 0;
    @(negedge clk);
    chk(heapEmpty == 1'b1, "R6 insert dropped", 64'(heapEmpty), 64'd1);
    chk(deqValid == 1'b0, "R10 single pulse", 64'(deqValid), 64'd0);
  endtask

  task automatic testFull;
    for (int i = 0; i < CAP; i++) doIns({32'(((i * 37 + 11) % 1024) + 5), 32'(i)});
    @(negedge clk);
    chk(heapFull == 1'b1, "R4 full flag", 64'(heapFull), 64'd1);
    chk(heapEmpty == 1'b0, "R8 not empty when full", 64'(heapEmpty), 64'd0);
    @(negedge clk);
    insReq = 1'b1; insEntry = {32'd0, 32'hDEAD};
    @(negedge clk);
    insReq = 1'b0;
    chk(opReady == 1'b1, "R4 insert on full ignored", 64'(opReady), 64'd1);
    doDeq("R4 after rejected insert");
    @(negedge clk);
    chk(heapFull == 1'b0, "R8 full drops", 64'(heapFull), 64'd0);
    drainAll("R4 drain");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testDescending();
    testInterleave();
    testTies();
    testEmptyDeq();
    testReadyGap();
    testPriority();
    testFull();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule